// File: doc/BRIEF.md
# Prefix-Coded Variable-Length Offset Decoder

This block sits beside an instruction decoder. It takes in an offset or immediate field one byte per cycle from the instruction byte stream, using a valid/ready handshake. The first byte of a field tells how long the field is. A run of leading one bits in that byte counts how many extra bytes follow, and a zero bit ends the run. Because of this, the decoder learns the field's length as soon as the first byte arrives. It does not have to wait for the whole field.

The payload is the bits of the first byte that follow the terminating zero, with every later byte appended below them. The block sign-extends the payload to a 32-bit value and presents it together with the field's byte count for one cycle. Only the one-byte short form can be scaled by an operand size, which suits element-indexed displacements. A prefix that is longer than the largest supported form is reported as an error, and that field is dropped.

Top module: `vlo_offset_decoder`

## Requirements
- R1: A first byte with bit 7 equal to 0 forms a 1-byte field. Its value is bits 6:0 read as a signed 7-bit number, and the reported length is 1.
- R2: A first byte whose top bits are 10 forms a 2-byte field. The value is 14 bits: first-byte bits 5:0 are the most significant part and the second byte is the least significant part. The reported length is 2.
- R3: A first byte whose top bits are 110 forms a 3-byte field. The value is 21 bits: first-byte bits 4:0 come first, then the second byte, then the third byte. The reported length is 3.
- R4: A first byte whose top bits are 1110 forms a 4-byte field. The value is 28 bits: first-byte bits 3:0 come first, then the three following bytes in arrival order. The reported length is 4.
- R5: A first byte whose top bits are 1111 raises the error output for one cycle and gives no done pulse. The next accepted byte is treated as the first byte of a new field.
- R6: The result is sign-extended to 32 bits from the most significant payload bit.
- R7: When scaleEn is 1 with a 1-byte field, the sign-extended value is multiplied by 2^sizeSel, so sizeSel values 0, 1, 2 and 3 give factors 1, 2, 4 and 8. sizeSel and scaleEn are sampled together with that byte.
- R8: Fields of 2 or more bytes are never scaled, whatever scaleEn and sizeSel are.
- R9: outDone is high for exactly the one cycle after the field's last byte is accepted. inReady is low during that cycle and high again in the following cycle.
- R10: A synchronous reset, applied even in the middle of a field, leaves inReady high with outDone and outErr low. The next byte accepted after it is treated as a first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A byte is offered on inByte |
| inReady | output | 1 | The block accepts a byte in this cycle |
| inByte | input | 8 | Stream byte |
| scaleEn | input | 1 | Enables scaling of the 1-byte form |
| sizeSel | input | 2 | Scale exponent (factor 1, 2, 4 or 8) |
| outDone | output | 1 | One-cycle pulse: the result is valid |
| outErr | output | 1 | One-cycle pulse: the prefix was too long |
| outValue | output | 32 | Sign-extended, possibly scaled value |
| outLen | output | 3 | Field length in bytes (1 to 4) |

## Verification
The bench builds the block with its defaults: a maximum field of 4 bytes and a 32-bit result. With these values every form from the 7-bit short field to the 28-bit long field can be reached, along with the all-ones prefix that sets the error output. These defaults also let the bench drive the sign bit of each form to both polarities and reach every scale factor. Fields are sent back to back, so the one-cycle ready gap and recovery after a reset in the middle of a field are observed directly at the ports.

// File: rtl/vlo_pkg.sv
package vlo_pkg;
  localparam int LEN_W = 3;

  typedef struct packed {
    logic             capFirst;
    logic             shiftByte;
    logic             finish;
    logic [LEN_W-1:0] len;
  } vloStrobe_t;

  typedef enum logic [1:0] {
    ST_FIRST   = 2'd0,
    ST_COLLECT = 2'd1,
    ST_PRESENT = 2'd2
  } vloState_t;
endpackage

// File: rtl/vlo_prefix_decode.sv
module vlo_prefix_decode #(
  parameter int MAX_BYTES = 4
) (
  input  logic [7:0]               firstByte,
  output logic [vlo_pkg::LEN_W-1:0] fieldLen,
  output logic                     tooLong
);
  localparam int LW = vlo_pkg::LEN_W;

  logic [LW-1:0] onesCnt;
  logic          stopped;

  // Count the run of leading ones, capped at MAX_BYTES.
  always_comb begin
    onesCnt = '0;
    stopped = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (!stopped) begin
        if (firstByte[i] && (int'(onesCnt) < MAX_BYTES)) onesCnt = onesCnt + 1'b1;
        else stopped = 1'b1;
      end
    end
  end

  assign tooLong  = (int'(onesCnt) >= MAX_BYTES);
  assign fieldLen = tooLong ? LW'(MAX_BYTES) : onesCnt + 1'b1;
endmodule

// File: rtl/vlo_ctrl.sv
module vlo_ctrl #(
  parameter int MAX_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [vlo_pkg::LEN_W-1:0] prefLen,
  input  logic                      prefErr,
  output vlo_pkg::vloStrobe_t       strobe,
  output logic                      outDone,
  output logic                      outErr
);
  import vlo_pkg::*;
  localparam int LW = LEN_W;

  vloState_t state, stateNxt;
  logic [LW-1:0] remain, remainNxt;
  logic [LW-1:0] curLen;
  logic          errHold;
  logic          accept;

  assign inReady = (state != ST_PRESENT);
  assign accept  = inValid && inReady;

  always_comb begin
    stateNxt         = state;
    remainNxt        = remain;
    strobe           = '0;
    strobe.len       = (state == ST_FIRST) ? prefLen : curLen;
    case (state)
      ST_FIRST: if (accept) begin
        if (prefErr) begin
          stateNxt = ST_PRESENT;
        end else begin
          strobe.capFirst = 1'b1;
          if (prefLen == LW'(1)) begin
            strobe.finish = 1'b1;
            stateNxt      = ST_PRESENT;
          end else begin
            remainNxt = prefLen - 1'b1;
            stateNxt  = ST_COLLECT;
          end
        end
      end
      ST_COLLECT: if (accept) begin
        strobe.shiftByte = 1'b1;
        remainNxt        = remain - 1'b1;
        if (remain == LW'(1)) begin
          strobe.finish = 1'b1;
          stateNxt      = ST_PRESENT;
        end
      end
      default: stateNxt = ST_FIRST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FIRST;
      remain  <= '0;
      curLen  <= '0;
      errHold <= 1'b0;
    end else begin
      state  <= stateNxt;
      remain <= remainNxt;
      if (state == ST_FIRST && accept) begin
        curLen  <= prefLen;
        errHold <= prefErr;
      end
    end
  end

  assign outDone = (state == ST_PRESENT) && !errHold;
  assign outErr  = (state == ST_PRESENT) && errHold;

  AST_READY_GAP: assert property (@(posedge clk) disable iff (rst)
    (outDone || outErr) |-> !inReady); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    outDone |=> (!outDone && inReady)); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(outDone && outErr)); // R5
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    outErr |=> (!outErr && inReady)); // R5
endmodule

// File: rtl/vlo_datapath.sv
module vlo_datapath #(
  parameter int MAX_BYTES = 4,
  parameter int OUT_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [7:0]                inByte,
  input  logic                      scaleEn,
  input  logic [1:0]                sizeSel,
  input  vlo_pkg::vloStrobe_t       strobe,
  output logic [OUT_W-1:0]          outValue,
  output logic [vlo_pkg::LEN_W-1:0] outLen
);
  import vlo_pkg::*;
  localparam int PAY_W = 7 * MAX_BYTES;

  logic [PAY_W-1:0] acc;
  logic [PAY_W-1:0] firstPay;
  logic [PAY_W-1:0] cand;
  logic [OUT_W-1:0] extVal [1:MAX_BYTES];
  logic [OUT_W-1:0] selVal;
  logic [OUT_W-1:0] finalVal;
  logic             lastFinish;

  // Keep only the bits after the prefix terminator.
  assign firstPay = PAY_W'(inByte & (8'h7F >> (strobe.len - 1'b1)));
  assign cand     = strobe.capFirst ? firstPay : {acc[PAY_W-9:0], inByte};

  for (genvar k = 1; k <= MAX_BYTES; k++) begin : g_ext
    localparam int B = 7 * k;
    assign extVal[k] = {{(OUT_W-B){cand[B-1]}}, cand[B-1:0]};
  end

  always_comb begin
    selVal = extVal[1];
    for (int k = 1; k <= MAX_BYTES; k++)
      if (strobe.len == LEN_W'(k)) selVal = extVal[k];
  end

  assign finalVal = (strobe.len == LEN_W'(1) && scaleEn) ? (selVal << sizeSel) : selVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      outValue   <= '0;
      outLen     <= '0;
      lastFinish <= 1'b0;
    end else begin
      lastFinish <= strobe.finish;
      if (strobe.capFirst || strobe.shiftByte) acc <= cand;
      if (strobe.finish) begin
        outValue <= finalVal;
        outLen   <= strobe.len;
      end
    end
  end

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    lastFinish |-> (outLen >= LEN_W'(1) && int'(outLen) <= MAX_BYTES)); // R1
  AST_LONG_SIGNEXT: assert property (@(posedge clk) disable iff (rst)
    (lastFinish && int'(outLen) == MAX_BYTES) |->
      ($countones(outValue[OUT_W-1:PAY_W-1]) == 0 ||
       $countones(outValue[OUT_W-1:PAY_W-1]) == OUT_W-PAY_W+1)); // R6
  AST_SHORT_UNSCALED: assert property (@(posedge clk) disable iff (rst)
    (strobe.finish && strobe.len == LEN_W'(1) && !scaleEn) |=>
      ($countones(outValue[OUT_W-1:6]) == 0 ||
       $countones(outValue[OUT_W-1:6]) == OUT_W-6)); // R7
endmodule

// File: rtl/vlo_offset_decoder.sv
module vlo_offset_decoder #(
  parameter int MAX_BYTES = 4,
  parameter int OUT_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [7:0]                inByte,
  input  logic                      scaleEn,
  input  logic [1:0]                sizeSel,
  output logic                      outDone,
  output logic                      outErr,
  output logic [OUT_W-1:0]          outValue,
  output logic [vlo_pkg::LEN_W-1:0] outLen
);
  import vlo_pkg::*;

  logic [LEN_W-1:0] prefLen;
  logic             prefErr;
  vloStrobe_t       strobe;

  vlo_prefix_decode #(.MAX_BYTES(MAX_BYTES)) prefix_i (
    .firstByte(inByte), .fieldLen(prefLen), .tooLong(prefErr));

  vlo_ctrl #(.MAX_BYTES(MAX_BYTES)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .prefLen(prefLen), .prefErr(prefErr), .strobe(strobe),
    .outDone(outDone), .outErr(outErr));

  vlo_datapath #(.MAX_BYTES(MAX_BYTES), .OUT_W(OUT_W)) dp_i (
    .clk(clk), .rst(rst), .inByte(inByte), .scaleEn(scaleEn),
    .sizeSel(sizeSel), .strobe(strobe), .outValue(outValue), .outLen(outLen));
endmodule

// File: tb/vlo_offset_decoder_tb.sv
module vlo_offset_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic        scaleEn = 1'b0;
  logic [1:0]  sizeSel = '0;
  logic        inReady, outDone, outErr;
  logic [31:0] outValue;
  logic [2:0]  outLen;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  vlo_offset_decoder dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inByte(inByte),
    .scaleEn(scaleEn), .sizeSel(sizeSel), .outDone(outDone), .outErr(outErr),
    .outValue(outValue), .outLen(outLen));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic putByte(input logic [7:0] b);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inByte  = b;
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  function automatic logic [31:0] model(input logic [7:0] b [4], input int n,
                                        input bit en, input int sz);
    longint v    = longint'(b[0]) & ((longint'(1) << (8 - n)) - 1);
    int     bits = 7 * n;
    for (int i = 1; i < n; i++) v = v * 256 + longint'(b[i]);
    if (v >= (longint'(1) << (bits - 1))) v = v - (longint'(1) << bits);
    if (n == 1 && en) v = v * (longint'(1) << sz);
    return v[31:0];
  endfunction

  task automatic sendField(input string tag, input logic [7:0] b [4], input int n,
                           input bit en, input int sz);
    logic [31:0] exp;
    exp = model(b, n, en, sz);
    scaleEn = en;
    sizeSel = 2'(sz);
    for (int i = 0; i < n; i++) putByte(b[i]);
    @(negedge clk);
    chk(outDone && !outErr, {tag, " done"}, outDone, 1);
    chk(!inReady, "R9 ready gap", inReady, 0);
    chk(outLen == 3'(n), {tag, " len"}, outLen, n);
    chk(outValue == exp, {tag, " value"}, outValue, exp);
    @(negedge clk);
    chk(!outDone && inReady, "R9 done one cycle", outDone, 0);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(inReady && !outDone && !outErr, "R10 reset state", {inReady, outDone, outErr}, 3'b100);
  endtask

  task automatic testShort();
    sendField("R1 pos", '{8'h05, 0, 0, 0}, 1, 0, 0);
    sendField("R1 R6 neg1", '{8'h7F, 0, 0, 0}, 1, 0, 0);
    sendField("R1 R6 min", '{8'h40, 0, 0, 0}, 1, 0, 0);
  endtask

  task automatic testTwo();
    sendField("R2 pos", '{8'h85, 8'h12, 0, 0}, 2, 0, 0);
    sendField("R2 R6 neg1", '{8'hBF, 8'hFF, 0, 0}, 2, 0, 0);
    sendField("R2 R6 min", '{8'hA0, 8'h00, 0, 0}, 2, 0, 0);
  endtask

  task automatic testThree();
    sendField("R3 pos", '{8'hC1, 8'h23, 8'h45, 0}, 3, 0, 0);
    sendField("R3 R6 neg", '{8'hDF, 8'h00, 8'h01, 0}, 3, 0, 0);
  endtask

  task automatic testFour();
    sendField("R4 pos", '{8'hE7, 8'h65, 8'h43, 8'h21}, 4, 0, 0);
    sendField("R4 R6 min", '{8'hE8, 8'h00, 8'h00, 8'h00}, 4, 0, 0);
  endtask

  task automatic testError();
    putByte(8'hF0);
    @(negedge clk);
    chk(outErr && !outDone, "R5 error pulse", {outErr, outDone}, 2'b10);
    @(negedge clk);
    chk(!outErr && inReady, "R5 error clears", outErr, 0);
    sendField("R5 next first", '{8'h03, 0, 0, 0}, 1, 0, 0);
  endtask

  task automatic testScale();
    sendField("R7 x8", '{8'h05, 0, 0, 0}, 1, 1, 3);
    sendField("R7 x4 neg", '{8'h7F, 0, 0, 0}, 1, 1, 2);
    sendField("R7 x2 min", '{8'h40, 0, 0, 0}, 1, 1, 1);
    sendField("R7 x1", '{8'h21, 0, 0, 0}, 1, 1, 0);
    sendField("R8 two byte", '{8'h81, 8'h00, 0, 0}, 2, 1, 3);
    sendField("R8 four byte", '{8'hE0, 8'h00, 8'h00, 8'h03}, 4, 1, 2);
  endtask

  task automatic testMidReset();
    putByte(8'hC1);
    putByte(8'h22);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(inReady && !outDone && !outErr, "R10 mid-field reset", {inReady, outDone, outErr}, 3'b100);
    sendField("R10 restart", '{8'h11, 0, 0, 0}, 1, 0, 0);
  endtask

  initial begin
    testReset();
    testShort();
    testTwo();
    testThree();
    testFour();
    testError();
    testScale();
    testMidReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule